// File: doc/BRIEF.md
# Conditional Move Evaluator

This block decides, for each SIMD chunk of a 64-bit word, whether a register move takes place, and produces the value to be written back. A 3-bit condition code chooses one of three base tests on a condition operand: the operand is zero, its top bit is set, or its bottom bit is set. The top bit of the code inverts the chosen test. Each chunk that passes takes its bits from the source operand. Each chunk that fails keeps its bits from the old destination value.

A select input switches between the two move forms. In the plain form the source is copied whole and the condition operand and code are ignored. In the conditional form the test is applied once per chunk, using that chunk's own bits only. The chunk width is chosen from 8, 16, 32 or 64 bits. Two code values carry no test. In the conditional form they raise an illegal flag and leave the destination as it was. Results are registered, so they appear one clock after the inputs.

Top module: `cmov_eval`

## Requirements
- R1: While reset is low, `dst_new`, `lane_taken` and `cond_illegal` are all zero. Outside reset, every output reflects the inputs sampled at the previous rising clock edge (one cycle latency).
- R2: When `cond_en` is 0, `dst_new` equals `src_val`, `lane_taken` is all ones and `cond_illegal` is 0, whatever `cond_code` and `cond_val` hold.
- R3: With `cond_en` 1, code 3'b000 passes a chunk whose bits are all zero, and code 3'b100 passes a chunk with at least one bit set.
- R4: With `cond_en` 1, code 3'b010 passes a chunk whose most significant bit is 1, and code 3'b110 passes a chunk whose most significant bit is 0.
- R5: With `cond_en` 1, code 3'b011 passes a chunk whose least significant bit is 1, and code 3'b111 passes a chunk whose least significant bit is 0.
- R6: With `cond_en` 1, codes 3'b001 and 3'b101 set `cond_illegal`, make `dst_new` equal `dst_old`, and clear `lane_taken`.
- R7: `chunk_sel` gives the chunk width as 8 << `chunk_sel` bits (0 is 8, 1 is 16, 2 is 32, 3 is 64). Each chunk is tested on its own bits only. A passing chunk takes its bits from `src_val`; a failing chunk keeps its bits from `dst_old`.
- R8: Bit i of `lane_taken` covers bits 8i+7 down to 8i of the data. Every lane bit within one chunk carries that chunk's result, so at a chunk width of 64 the mask is all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_en | input | 1 | 1 selects the conditional form, 0 the plain copy |
| cond_code | input | 3 | Condition code: bit 2 inverts, bits 1:0 choose the base test |
| chunk_sel | input | 2 | Chunk width select, 8 << chunk_sel bits |
| cond_val | input | 64 | Operand the condition is tested on |
| src_val | input | 64 | Value moved when a chunk passes |
| dst_old | input | 64 | Current destination value |
| dst_new | output | 64 | Destination value to write back |
| lane_taken | output | 8 | Per-byte-lane pass mask |
| cond_illegal | output | 1 | Set for an unassigned code in the conditional form |

## Verification
A fault in the per-chunk test or in the width selection shows up as `lane_taken` bits that differ from the chunk result. The faulty lanes also hold the wrong byte in `dst_new`, on the cycle right after the stimulus. A wrong lane-to-byte expansion shows as `dst_new` bytes that disagree with a correct `lane_taken`. A faulty result register shows as nonzero outputs during reset, or as outputs a cycle late. The bench compares all three outputs against its reference on every clock, using directed patterns for each code and each width and then a long run of biased random operands. As a result, each such fault is seen within one cycle of the first vector that reaches it.

// File: rtl/cmov_pkg.sv
package cmov_pkg;

   localparam int CODE_W = 3;

   // Base tests selected by code bits 1:0; code bit 2 inverts the result.
   typedef enum logic [1:0] {
      TEST_ZERO   = 2'b00,
      TEST_UNUSED = 2'b01,
      TEST_MSB    = 2'b10,
      TEST_LSB    = 2'b11
   } base_test_e;

   function automatic logic code_unassigned(input logic [CODE_W-1:0] code);
      return base_test_e'(code[1:0]) == TEST_UNUSED;
   endfunction

endpackage

// File: rtl/cmov_chunk_test.sv
module cmov_chunk_test #(
   parameter int W = 8
) (
   input  logic [W-1:0]                 chunk,
   input  logic [cmov_pkg::CODE_W-1:0]  code,
   output logic                         pass
);
   import cmov_pkg::*;

   logic base;

   always_comb begin
      unique case (base_test_e'(code[1:0]))
         TEST_ZERO: base = ~|chunk;
         TEST_MSB:  base = chunk[W-1];
         TEST_LSB:  base = chunk[0];
         default:   base = 1'b0;
      endcase
      pass = base ^ code[2];
   end

endmodule

// File: rtl/cmov_size_bank.sv
module cmov_size_bank #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   localparam int NLANES = DATA_W / LANE_W,
   localparam int NSIZES = $clog2(NLANES) + 1
) (
   input  logic [DATA_W-1:0]                   cond_val,
   input  logic [cmov_pkg::CODE_W-1:0]         cond_code,
   output logic [NSIZES-1:0][NLANES-1:0]       size_masks
);

   for (genvar s = 0; s < NSIZES; s++) begin : g_size
      localparam int CW  = LANE_W << s;
      localparam int NCH = DATA_W / CW;
      localparam int LPC = CW / LANE_W;
      for (genvar c = 0; c < NCH; c++) begin : g_chunk
         logic pass;
         cmov_chunk_test #(.W(CW)) u_test (
            .chunk (cond_val[c*CW +: CW]),
            .code  (cond_code),
            .pass  (pass)
         );
         assign size_masks[s][c*LPC +: LPC] = {LPC{pass}};
      end
   end

endmodule

// File: rtl/cmov_lane_expand.sv
module cmov_lane_expand #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   localparam int NLANES = DATA_W / LANE_W
) (
   input  logic [NLANES-1:0] lane_mask,
   output logic [DATA_W-1:0] bit_mask
);

   for (genvar l = 0; l < NLANES; l++) begin : g_lane
      assign bit_mask[l*LANE_W +: LANE_W] = {LANE_W{lane_mask[l]}};
   end

endmodule

// File: rtl/cmov_eval.sv
module cmov_eval #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   localparam int NLANES = DATA_W / LANE_W,
   localparam int NSIZES = $clog2(NLANES) + 1,
   localparam int SZ_W   = (NSIZES > 1) ? $clog2(NSIZES) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cond_en,
   input  logic [cmov_pkg::CODE_W-1:0]   cond_code,
   input  logic [SZ_W-1:0]               chunk_sel,
   input  logic [DATA_W-1:0]             cond_val,
   input  logic [DATA_W-1:0]             src_val,
   input  logic [DATA_W-1:0]             dst_old,
   output logic [DATA_W-1:0]             dst_new,
   output logic [NLANES-1:0]             lane_taken,
   output logic                          cond_illegal
);

   // Elaboration-time parameter checks
   if (LANE_W < 1) begin : g_bad_lane
      $error("cmov_eval: LANE_W must be positive");
   end
   if (DATA_W % LANE_W != 0) begin : g_bad_div
      $error("cmov_eval: DATA_W must be a multiple of LANE_W");
   end
   if ((1 << (NSIZES - 1)) != NLANES) begin : g_bad_pow
      $error("cmov_eval: DATA_W / LANE_W must be a power of two");
   end

   logic [NSIZES-1:0][NLANES-1:0] size_masks;
   logic [NLANES-1:0]             chunk_mask;
   logic [NLANES-1:0]             lane_d;
   logic [DATA_W-1:0]             bit_mask;
   logic [DATA_W-1:0]             dst_d;
   logic                          unassigned;
   logic                          illegal_d;

   cmov_size_bank #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_bank (
      .cond_val   (cond_val),
      .cond_code  (cond_code),
      .size_masks (size_masks)
   );

   // Pick the mask for the selected width; out-of-range selects use the widest.
   always_comb begin
      chunk_mask = size_masks[NSIZES-1];
      for (int s = 0; s < NSIZES - 1; s++) begin
         if (chunk_sel == SZ_W'(s)) chunk_mask = size_masks[s];
      end
   end

   assign unassigned = cmov_pkg::code_unassigned(cond_code);
   assign illegal_d  = cond_en & unassigned;

   always_comb begin
      if (!cond_en)        lane_d = '1;
      else if (unassigned) lane_d = '0;
      else                 lane_d = chunk_mask;
   end

   cmov_lane_expand #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_expand (
      .lane_mask (lane_d),
      .bit_mask  (bit_mask)
   );

   assign dst_d = (src_val & bit_mask) | (dst_old & ~bit_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_new      <= '0;
         lane_taken   <= '0;
         cond_illegal <= 1'b0;
      end else begin
         dst_new      <= dst_d;
         lane_taken   <= lane_d;
         cond_illegal <= illegal_d;
      end
   end

endmodule

// File: rtl/cmov_eval_chk.sv
module cmov_eval_chk #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   localparam int NLANES = DATA_W / LANE_W,
   localparam int NSIZES = $clog2(NLANES) + 1,
   localparam int SZ_W   = (NSIZES > 1) ? $clog2(NSIZES) : 1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cond_en,
   input logic [2:0]                  cond_code,
   input logic [SZ_W-1:0]             chunk_sel,
   input logic [DATA_W-1:0]           cond_val,
   input logic [DATA_W-1:0]           src_val,
   input logic [DATA_W-1:0]           dst_old,
   input logic [DATA_W-1:0]           dst_new,
   input logic [NLANES-1:0]           lane_taken,
   input logic                        cond_illegal
);

   logic primed;
   always_ff @(posedge clk) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   logic [DATA_W-1:0] out_bits;
   always_comb begin
      for (int l = 0; l < NLANES; l++)
         out_bits[l*LANE_W +: LANE_W] = {LANE_W{lane_taken[l]}};
   end

   localparam logic [SZ_W-1:0] WIDEST = SZ_W'(NSIZES - 1);

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |=> (!rst_n || (dst_new == '0 && lane_taken == '0 && !cond_illegal)));

   // R2
   plain_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(!cond_en) |->
         dst_new == $past(src_val) && &lane_taken && !cond_illegal);

   // R3
   zero_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(cond_en && cond_code == 3'b000 && chunk_sel == WIDEST) |->
         (&lane_taken) == ($past(cond_val) == '0));

   // R4
   msb_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(cond_en && cond_code == 3'b010 && chunk_sel == WIDEST) |->
         (&lane_taken) == $past(cond_val[DATA_W-1]));

   // R5
   lsb_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(cond_en && cond_code == 3'b111 && chunk_sel == WIDEST) |->
         (&lane_taken) == !$past(cond_val[0]));

   // R6
   unassigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(cond_en && cond_code[1:0] == 2'b01) |->
         cond_illegal && lane_taken == '0 && dst_new == $past(dst_old));

   // R6
   illegal_only_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed && cond_illegal |-> $past(cond_en));

   // R7
   merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |->
         dst_new == (($past(src_val) & out_bits) | ($past(dst_old) & ~out_bits)));

   // R8
   widest_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(chunk_sel == WIDEST) |->
         (lane_taken == '0 || &lane_taken));

endmodule

bind cmov_eval cmov_eval_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cond_en      (cond_en),
   .cond_code    (cond_code),
   .chunk_sel    (chunk_sel),
   .cond_val     (cond_val),
   .src_val      (src_val),
   .dst_old      (dst_old),
   .dst_new      (dst_new),
   .lane_taken   (lane_taken),
   .cond_illegal (cond_illegal)
);

// File: tb/tb_cmov_eval.sv
`timescale 1ns/1ps
module tb_cmov_eval;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cond_en = 1'b0;
   logic [2:0]  cond_code = 3'b0;
   logic [1:0]  chunk_sel = 2'b0;
   logic [63:0] cond_val = '0, src_val = '0, dst_old = '0;
   logic [63:0] dst_new;
   logic [7:0]  lane_taken;
   logic        cond_illegal;

   cmov_eval dut (
      .clk(clk), .rst_n(rst_n), .cond_en(cond_en), .cond_code(cond_code),
      .chunk_sel(chunk_sel), .cond_val(cond_val), .src_val(src_val),
      .dst_old(dst_old), .dst_new(dst_new), .lane_taken(lane_taken),
      .cond_illegal(cond_illegal)
   );

   always #2.5 clk = ~clk;

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   logic [63:0] exp_d;
   logic [7:0]  exp_m;
   logic        exp_i;
   string       exp_tag;
   bit          pending = 1'b0;

   // Behavioural reference: returns per-lane mask, data and illegal flag.
   task automatic model(input bit en, input bit [2:0] code, input bit [1:0] sel,
                        input bit [63:0] cv, input bit [63:0] sv, input bit [63:0] dv,
                        output logic [63:0] d, output logic [7:0] m, output logic i);
      int cw = 8 << sel;
      m = '0;
      i = 1'b0;
      if (!en) m = 8'hFF;
      else if (code == 3'b001 || code == 3'b101) i = 1'b1;
      else begin
         for (int c = 0; c < 64 / cw; c++) begin
            bit is_zero = 1'b1;
            bit ok;
            for (int b = 0; b < cw; b++) if (cv[c*cw + b]) is_zero = 1'b0;
            case (code)
               3'b000: ok = is_zero;
               3'b100: ok = !is_zero;
               3'b010: ok = cv[c*cw + cw - 1];
               3'b110: ok = !cv[c*cw + cw - 1];
               3'b011: ok = cv[c*cw];
               default: ok = !cv[c*cw];
            endcase
            for (int l = 0; l < cw / 8; l++) m[c*(cw/8) + l] = ok;
         end
      end
      for (int b = 0; b < 64; b++) d[b] = m[b/8] ? sv[b] : dv[b];
   endtask

   task automatic check_pending();
      if (pending) begin
         checks++;
         if (dst_new !== exp_d || lane_taken !== exp_m || cond_illegal !== exp_i) begin
            fails++;
            $display("FAIL %s: dst %h mask %h ill %b, expected dst %h mask %h ill %b",
                     exp_tag, dst_new, lane_taken, cond_illegal, exp_d, exp_m, exp_i);
         end
      end
      pending = 1'b0;
   endtask

   task automatic apply(input bit en, input bit [2:0] code, input bit [1:0] sel,
                        input bit [63:0] cv, input bit [63:0] sv, input bit [63:0] dv,
                        input string tag);
      @(negedge clk);
      check_pending();
      cond_en = en; cond_code = code; chunk_sel = sel;
      cond_val = cv; src_val = sv; dst_old = dv;
      model(en, code, sel, cv, sv, dv, exp_d, exp_m, exp_i);
      exp_tag = tag;
      pending = 1'b1;
   endtask

   function automatic bit [63:0] biased_word();
      bit [63:0] w = {$urandom, $urandom};
      bit [7:0]  z = 8'($urandom);
      for (int k = 0; k < 8; k++) if (z[k]) w[k*8 +: 8] = 8'h00;
      if ($urandom_range(0, 7) == 0) w = '0;
      return w;
   endfunction

   localparam bit [63:0] SRC = 64'hA5A5_5A5A_C3C3_3C3C;
   localparam bit [63:0] OLD = 64'h1122_3344_5566_7788;

   initial begin
      // R1: outputs held at zero in reset despite active inputs
      cond_en = 1'b0; src_val = SRC; dst_old = OLD; cond_val = 64'h1;
      repeat (3) begin
         @(negedge clk);
         checks++;
         if (dst_new !== '0 || lane_taken !== '0 || cond_illegal !== 1'b0) begin
            fails++;
            $display("FAIL R1: dst %h mask %h ill %b, expected all zero",
                     dst_new, lane_taken, cond_illegal);
         end
      end
      rst_n = 1'b1;

      // R2: plain copy ignores code and condition operand
      apply(1'b0, 3'b001, 2'd0, 64'h0,  SRC, OLD, "R2 plain unassigned code");
      apply(1'b0, 3'b000, 2'd3, 64'h5,  OLD, SRC, "R2 plain copy");
      // R3
      apply(1'b1, 3'b000, 2'd3, 64'h0,  SRC, OLD, "R3 zero pass");
      apply(1'b1, 3'b000, 2'd3, 64'h1,  SRC, OLD, "R3 zero fail");
      apply(1'b1, 3'b100, 2'd3, 64'h0,  SRC, OLD, "R3 nonzero fail");
      apply(1'b1, 3'b100, 2'd3, 64'h8000_0000_0000_0000, SRC, OLD, "R3 nonzero pass");
      apply(1'b1, 3'b000, 2'd0, 64'h00FF_0000_1200_0001, SRC, OLD, "R3 R8 zero bytes");
      // R4
      apply(1'b1, 3'b010, 2'd1, 64'h8000_0001_7FFF_8000, SRC, OLD, "R4 msb halves");
      apply(1'b1, 3'b110, 2'd1, 64'h8000_0001_7FFF_8000, SRC, OLD, "R4 msb clear halves");
      apply(1'b1, 3'b010, 2'd3, 64'h8000_0000_0000_0000, SRC, OLD, "R4 msb full");
      // R5
      apply(1'b1, 3'b011, 2'd2, 64'h0000_0001_FFFF_FFFE, SRC, OLD, "R5 lsb words");
      apply(1'b1, 3'b111, 2'd2, 64'h0000_0001_FFFF_FFFE, SRC, OLD, "R5 lsb clear words");
      apply(1'b1, 3'b011, 2'd0, 64'h0101_0000_0001_0100, SRC, OLD, "R5 lsb bytes");
      // R6
      apply(1'b1, 3'b001, 2'd0, 64'h0,  SRC, OLD, "R6 code 001");
      apply(1'b1, 3'b101, 2'd3, 64'hF,  SRC, OLD, "R6 code 101");
      // R7 R8: chunk isolation, a single set bit at each chunk boundary
      for (int s = 0; s < 4; s++)
         apply(1'b1, 3'b000, 2'(s), 64'h0000_0001_0000_0080, SRC, OLD, "R7 R8 width");
      // R7 R8: biased random
      for (int n = 0; n < 400; n++)
         apply($urandom_range(0, 5) != 0, 3'($urandom), 2'($urandom),
               biased_word(), {$urandom, $urandom}, {$urandom, $urandom},
               "R7 R8 random");
      @(negedge clk);
      check_pending();
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule